// File: doc/BRIEF.md
# Manchester Line Encoder with Start-of-Idle Pulse

This block sits between a MAC-side serial transmit interface and a line driver. It runs on a 20 MHz master clock. From that clock it derives a 10 MHz transmit clock for the MAC. While the transmit enable is active, it samples one data bit per transmit clock period. Each bit becomes a two-half Manchester cell on a single-bit line output, and each half lasts one master cycle. A second output, `line_act`, marks the cycles that belong to a frame or to its closing pulse.

A frame is closed when the enable is found inactive at a sampling point. The last cell ends at its centre if the final bit was one, and at its boundary if it was zero. In both cases the line is then held high, so that it stays high for exactly `SOI_CYC` master cycles after the last low-to-high transition. After that the line returns to low idle. This positive pulse marks the start of idle. A mode input selects whether the enable input is active high or active low, so the block fits either kind of controller. `SOI_CYC` must be at least 2; the default of 5 gives 250 ns.

Top module: `mtx_line_encoder`

## Requirements
- R1: `txc` is low while reset is held. After reset it toggles on every master clock edge, which gives half the master rate.
- R2: Data and enable are sampled on the master edges where `txc` falls from 1 to 0. A frame starts at the first such edge with the enable active, and the first half of that bit appears on `line_out` in the master cycle right after that edge.
- R3: Each bit occupies two master cycles on `line_out`: first the complement of the bit, then the bit itself.
- R4: With `ctrl_alt` = 0 the enable `tx_en_in` is active high. With `ctrl_alt` = 1 it is active low.
- R5: When the enable is inactive at a sampling edge, the frame ends after the last cell: at its centre if the last bit is 1, and at its boundary if the last bit is 0. In both cases the line is high in the cycle after that edge.
- R6: After the last low-to-high transition of a frame, `line_out` stays high for exactly `SOI_CYC` master cycles and is then low.
- R7: Outside a frame and its closing pulse, `line_out` and `line_act` are both low. `line_act` is high in every cycle of a frame and of its pulse.
- R8: An enable that becomes active again during the closing pulse has no effect on the pulse. Bits sampled during the pulse are dropped. The next frame starts at the first sampling edge after the cycle in which the line has returned to idle.
- R9: While reset is held, `line_out`, `line_act` and `txc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctrl_alt | input | 1 | Enable polarity select (0: active high, 1: active low) |
| tx_en_in | input | 1 | Transmit enable from the MAC |
| txd | input | 1 | Serial transmit data from the MAC |
| txc | output | 1 | Derived transmit clock, half the master rate |
| line_out | output | 1 | Manchester-coded line bit |
| line_act | output | 1 | High during a frame and its start-of-idle pulse |

## Verification
Master cycles are numbered from the first sampling edge of a run. A bit driven for sampling edge 2j shows its first half in cycle 2j and its second half in cycle 2j+1. A frame whose enable is found inactive at edge 2e holds the line high through cycle 2e+SOI_CYC-2 if its last bit was one, and through 2e+SOI_CYC-1 if it was zero. The bench places these expectations in a per-cycle table. It drives inputs and samples outputs at the falling master edge that follows each numbered edge, so each cycle is compared with exactly its own table entry. Random frame lengths, data and gaps, including one-slot gaps that land inside the pulse, are run under both enable polarities.

// File: rtl/mtx_pkg.sv
package mtx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CELL = 2'd1,
    ST_SOI  = 2'd2
  } mtx_state_e;

  // Level of the first half of a Manchester cell for data bit b.
  function automatic logic first_half_level(input logic b);
    return ~b;
  endfunction

  // Number of further high cycles after the frame-closing edge.
  // A trailing one has already shown one high half, a trailing zero has not.
  function automatic int unsigned soi_remaining(input logic last_bit,
                                                input int unsigned soi_cyc);
    return last_bit ? (soi_cyc - 2) : (soi_cyc - 1);
  endfunction

endpackage

// File: rtl/mtx_clkdiv.sv
module mtx_clkdiv (
  input  logic clk,
  input  logic rst_n,
  output logic txc,
  output logic samp
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign txc  = phase_q;
  // The edge taken while txc is high is its falling edge: sampling point.
  assign samp = phase_q;

  a_r1_txc_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (txc != $past(txc)));

endmodule

// File: rtl/mtx_soi_timer.sv
module mtx_soi_timer #(
  parameter int unsigned SOI_CYC = 5,
  localparam int unsigned CW = $clog2(SOI_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  a_r6_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(SOI_CYC - 1));

endmodule

// File: rtl/mtx_cell_shaper.sv
module mtx_cell_shaper
  import mtx_pkg::*;
#(
  parameter int unsigned SOI_CYC = 5,
  localparam int unsigned CW = $clog2(SOI_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp,
  input  logic          en,
  input  logic          d,
  input  logic          soi_done,
  output logic          soi_load,
  output logic [CW-1:0] soi_val,
  output logic          soi_run,
  output logic          line,
  output logic          act
);
  mtx_state_e st_q;
  logic       bit_q;
  logic       first_half_q;   // line currently shows the first half of a cell
  logic       frame_close;    // sampling edge that ends a frame

  assign frame_close = (st_q == ST_CELL) && samp && !en;
  assign soi_load    = frame_close;
  assign soi_val     = CW'(soi_remaining(bit_q, SOI_CYC));
  assign soi_run     = (st_q == ST_SOI) && !soi_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      bit_q        <= 1'b0;
      line         <= 1'b0;
      act          <= 1'b0;
      first_half_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (samp && en) begin
            st_q         <= ST_CELL;
            bit_q        <= d;
            line         <= first_half_level(d);
            act          <= 1'b1;
            first_half_q <= 1'b1;
          end else begin
            line         <= 1'b0;
            act          <= 1'b0;
            first_half_q <= 1'b0;
          end
        end
        ST_CELL: begin
          if (!samp) begin
            line         <= bit_q;
            first_half_q <= 1'b0;
          end else if (en) begin
            bit_q        <= d;
            line         <= first_half_level(d);
            first_half_q <= 1'b1;
          end else begin
            st_q         <= ST_SOI;
            line         <= 1'b1;
            first_half_q <= 1'b0;
          end
        end
        ST_SOI: begin
          first_half_q <= 1'b0;
          if (soi_done) begin
            st_q <= ST_IDLE;
            line <= 1'b0;
            act  <= 1'b0;
          end else begin
            line <= 1'b1;
          end
        end
        default: begin
          st_q         <= ST_IDLE;
          line         <= 1'b0;
          act          <= 1'b0;
          first_half_q <= 1'b0;
        end
      endcase
    end
  end

  // Checker state: length of the current run of high line cycles.
  logic [7:0] hi_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)     hi_run_q <= '0;
    else if (!line) hi_run_q <= '0;
    else if (hi_run_q != 8'hFF) hi_run_q <= hi_run_q + 1'b1;
  end

  a_r3_mid_cell_flip: assert property (@(posedge clk) disable iff (!rst_n)
    first_half_q |=> (line != $past(line)));

  a_r7_idle_is_low: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> !line);

  a_r6_high_run_limit: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run_q <= 8'(SOI_CYC));

  a_r6_ends_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act) |-> $past(line));

  a_r8_pulse_not_cut: assert property (@(posedge clk) disable iff (!rst_n)
    soi_run |=> (act && line));

endmodule

// File: rtl/mtx_line_encoder.sv
module mtx_line_encoder #(
  parameter int unsigned SOI_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_alt,
  input  logic tx_en_in,
  input  logic txd,
  output logic txc,
  output logic line_out,
  output logic line_act
);
  localparam int unsigned CW = $clog2(SOI_CYC + 1);

  logic          samp;
  logic          en_eff;
  logic          soi_load;
  logic [CW-1:0] soi_val;
  logic          soi_run;
  logic          soi_done;

  // Enable polarity follows the controller mode.
  assign en_eff = tx_en_in ^ ctrl_alt;

  mtx_clkdiv u_clkdiv (
    .clk   (clk),
    .rst_n (rst_n),
    .txc   (txc),
    .samp  (samp)
  );

  mtx_soi_timer #(.SOI_CYC(SOI_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (soi_load),
    .load_val (soi_val),
    .run      (soi_run),
    .done     (soi_done)
  );

  mtx_cell_shaper #(.SOI_CYC(SOI_CYC)) u_shaper (
    .clk      (clk),
    .rst_n    (rst_n),
    .samp     (samp),
    .en       (en_eff),
    .d        (txd),
    .soi_done (soi_done),
    .soi_load (soi_load),
    .soi_val  (soi_val),
    .soi_run  (soi_run),
    .line     (line_out),
    .act      (line_act)
  );

  a_r9_reset_quiet: assert property (@(posedge clk)
    $past(!rst_n) |-> (!line_out && !line_act));

endmodule

// File: tb/test_mtx_line_encoder.sv
module test_mtx_line_encoder;
  localparam int CLK_NS  = 50;
  localparam int SOI     = 5;
  localparam int NS      = 400;
  localparam int NC      = 2 * NS + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_alt = 1'b0;
  logic tx_en_in = 1'b0;
  logic txd = 1'b0;
  logic txc, line_out, line_act;

  mtx_line_encoder #(.SOI_CYC(SOI)) i_mtx_line_encoder (
    .clk(clk), .rst_n(rst_n), .ctrl_alt(ctrl_alt), .tx_en_in(tx_en_in),
    .txd(txd), .txc(txc), .line_out(line_out), .line_act(line_act)
  );

  always #(CLK_NS/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic en_s [NS];
  logic d_s  [NS];
  logic exp_line [NC];
  logic exp_act  [NC];
  int   exp_kind [NC];  // 0 idle,1 cell,2 pulse,3 start,4 close,5 late start
  int   p;

  task automatic chk(string tag, logic act_v, logic exp_v, int cyc);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act_v, exp_v);
    end
  endtask

  task automatic put(logic e, logic d);
    if (p < NS) begin en_s[p] = e; d_s[p] = d; p++; end
  endtask

  // Expected waveform from the slot stimulus, frame by frame.
  task automatic build_model(output int nframes);
    int ready, j, e, last_hi, first_hi, prev_e;
    bit lost;
    nframes = 0;
    for (int c = 0; c < NC; c++) begin
      exp_line[c] = 1'b0; exp_act[c] = 1'b0; exp_kind[c] = 0;
    end
    ready = 0; j = 0; prev_e = 0;
    while (j < NS) begin
      if (en_s[j] && j >= ready) begin
        lost = 0;
        for (int k = prev_e; k < j; k++) if (en_s[k]) lost = 1;
        e = j;
        while (e < NS && en_s[e]) e++;
        for (int i = j; i < e; i++) begin
          exp_line[2*i]   = ~d_s[i];
          exp_line[2*i+1] = d_s[i];
          exp_act[2*i]    = 1'b1;
          exp_act[2*i+1]  = 1'b1;
          exp_kind[2*i]   = 1;
          exp_kind[2*i+1] = 1;
        end
        exp_kind[2*j] = lost ? 5 : 3;
        first_hi = d_s[e-1] ? 2*e - 1 : 2*e;
        last_hi  = first_hi + SOI - 1;
        for (int c = 2*e; c <= last_hi; c++) begin
          exp_line[c] = 1'b1; exp_act[c] = 1'b1; exp_kind[c] = 2;
        end
        exp_kind[last_hi+1] = 2;
        exp_kind[2*e] = 4;
        if (d_s[e-1]) exp_kind[2*e-1] = 4;
        ready = (last_hi + 3) / 2;
        prev_e = e;
        nframes++;
        j = e;
      end else begin
        j++;
      end
    end
  endtask

  task automatic make_stim();
    int len, gap;
    for (int i = 0; i < NS; i++) begin en_s[i] = 1'b0; d_s[i] = 1'b0; end
    p = 2;
    // directed: lone one, one-slot gap into the pulse, lone zero
    put(1, 1); put(0, 0); put(1, 0); put(1, 1); put(0, 0);
    put(0, 0); put(0, 0); put(0, 0); put(0, 0);
    put(1, 0); put(0, 0); put(0, 0); put(0, 0); put(0, 0); put(0, 0);
    put(1, 0); put(1, 1); put(1, 0); put(0, 0); put(1, 1); put(1, 1);
    put(0, 0); put(0, 0); put(0, 0); put(0, 0); put(0, 0);
    while (p < NS - 30) begin
      len = 1 + int'($urandom % 12);
      for (int i = 0; i < len; i++) put(1, logic'($urandom % 2));
      gap = 1 + int'($urandom % 6);
      for (int i = 0; i < gap; i++) put(0, 0);
    end
  endtask

  task automatic run_pass(logic alt, output int frames_seen, output int frames_exp);
    logic prev_act;
    string tag;
    make_stim();
    build_model(frames_exp);
    @(negedge clk);
    ctrl_alt = alt; tx_en_in = alt; txd = 1'b0;
    repeat (4) @(negedge clk);
    while (!txc) @(negedge clk);
    tx_en_in = en_s[0] ^ alt; txd = d_s[0];
    frames_seen = 0; prev_act = 1'b0;
    for (int c = 0; c < 2*NS; c++) begin
      @(negedge clk);
      chk("R1", txc, logic'(c % 2 == 0 ? 0 : 1), c);
      case (exp_kind[c])
        1: tag = "R3";
        2: tag = "R6";
        3: tag = "R2";
        4: tag = "R5";
        5: tag = "R8";
        default: tag = "R7";
      endcase
      chk(tag, line_out, exp_line[c], c);
      chk("R7", line_act, exp_act[c], c);
      if (line_act && !prev_act) frames_seen++;
      prev_act = line_act;
      if (c % 2 == 1 && (c+1)/2 < NS) begin
        tx_en_in = en_s[(c+1)/2] ^ alt;
        txd      = d_s[(c+1)/2];
      end
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    int fs0, fe0, fs1, fe1;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R9: outputs quiet while reset is held
    chk("R9", line_out, 1'b0, -1);
    chk("R9", line_act, 1'b0, -1);
    chk("R9", txc, 1'b0, -1);
    @(negedge clk);
    rst_n = 1'b1;
    run_pass(1'b0, fs0, fe0);
    n_chk++;
    if (fs0 != fe0) begin
      n_bad++;
      $display("FAIL R2 frame count high-active: actual %0d expected %0d", fs0, fe0);
    end
    // R4: same traffic with enable active low
    run_pass(1'b1, fs1, fe1);
    n_chk++;
    if (fs1 != fe1) begin
      n_bad++;
      $display("FAIL R4 frame count low-active: actual %0d expected %0d", fs1, fe1);
    end
    // R4: in low-active mode a high enable level is idle
    @(negedge clk); tx_en_in = 1'b1; txd = 1'b1;
    repeat (8) @(negedge clk);
    chk("R4", line_act, 1'b0, -2);
    chk("R4", line_out, 1'b0, -2);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule